// File: doc/BRIEF.md
# Triggered Pre-Trigger Delay Sequencer

This block schedules the sampling points of an analog converter inside a control period. A trigger pulse, usually the start of a PWM period, clears a 16-bit tick counter and arms a table of up to eight slots. Each slot has an enable bit, a delay in counter ticks and a converter channel number. When the counter reaches a slot's delay, the slot asks the converter for a conversion on its channel. Slots with smaller delays therefore convert first. A typical use places a current sample at delay zero and a bus-voltage sample at mid-period.

Only one conversion may be in flight. Issuing a start sets a lock, and only the converter's conversion-complete pulse releases it. A slot that comes due while the lock is held does not start. Instead it raises a one-cycle sequence-error pulse, meant as an interrupt request, and is dropped from the current period. The slot table is captured into shadow registers on each trigger, so software may rewrite it during a period without disturbing the running sequence. A trigger that arrives mid-sequence discards the remaining slots and starts over from tick zero.

Top module: `pretrig_seq`

## Requirements
- R1: After a synchronous reset, `conv_start_o` and `seq_err_o` stay low and `conv_chan_o` is 0 until a trigger arrives, whatever `conv_done_i` does.
- R2: An enabled slot with delay d, evaluated with the lock free, produces a one-cycle `conv_start_o` pulse at the (d+1)-th rising edge after the edge that samples `trig_i` high. In that cycle `conv_chan_o` shows the slot's channel and holds it until the next start.
- R3: Slots start in order of delay. When several slots are due together, the lowest slot index is taken first and each following one is taken one cycle later, at most one slot per cycle.
- R4: A slot whose enable bit is 0 when the trigger is sampled never starts and never raises an error in that period.
- R5: After a start, no further start occurs until `conv_done_i` is sampled high. A completion sampled in the same cycle that a slot is due releases the lock and lets that slot start in that cycle.
- R6: A slot that comes due while the lock is held and `conv_done_i` is low produces a one-cycle `seq_err_o` pulse in place of its start. It is dropped and does not start later in that period. A start and an error never share a cycle.
- R7: Changes to `slot_en_i`, `slot_dly_i` or `slot_chan_i` after the trigger has no effect on the running sequence. They take effect at the next trigger.
- R8: A trigger sampled while a sequence is running resets the counter to 0 at that edge. It discards all slots still pending and re-arms the sequence from the new enable set. The lock is not cleared.
- R9: Delays cover the full 16-bit range. A slot with delay 65535 starts at the 65536th edge after the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, the PWM tick time base |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Sequence trigger, sampled each rising edge |
| slot_en_i | input | 8 | Per-slot enable, bit i for slot i |
| slot_dly_i | input | 128 | Per-slot delay, slot i in bits [16i+15:16i] |
| slot_chan_i | input | 40 | Per-slot channel, slot i in bits [5i+4:5i] |
| conv_done_i | input | 1 | Conversion-complete pulse from the converter |
| conv_start_o | output | 1 | One-cycle conversion start request |
| conv_chan_o | output | 5 | Channel of the most recent start |
| seq_err_o | output | 1 | One-cycle sequence-error interrupt request |

## Verification
Embedded properties check on every cycle the rules that hold at any instant. A trigger always zeroes the counter. Slot selection is never more than one-hot. No start follows a cycle in which the lock was held without a completion. An error needs a held lock, a start needs a running sequence, and the two are never asserted together. Only the bench scenarios can show the exact tick at which each slot fires, the order of tied delays, and that a disabled slot stays silent. The same applies to shadow-register isolation from mid-period writes, the abort on a second trigger, and the full-range delay, since each of these depends on the programmed table and on when the converter answers.

// File: rtl/pretrig_seq_pkg.sv
// Package: default dimensions shared by the sequencer modules.
// Assumes: the top exposes these as its parameter defaults.
package pretrig_seq_pkg;
    localparam int unsigned SEQ_SLOTS = 8;   // number of pre-trigger slots
    localparam int unsigned SEQ_CNT_W = 16;  // delay counter width
    localparam int unsigned SEQ_CH_W  = 5;   // converter channel select width
endpackage

// File: rtl/pretrig_timebase.sv
// Module: tick counter of the sequencer.
// A trigger clears the counter and marks the sequence running. While running,
// the counter increments and saturates at its maximum. The sequence stops once
// no slot is left pending. Assumes more_i is valid in every running cycle.
module pretrig_timebase #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             more_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Restart on trigger, otherwise count with saturation while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
            run_o <= 1'b0;
        end else if (trig_i) begin
            cnt_o <= '0;
            run_o <= 1'b1;
        end else if (run_o) begin
            run_o <= more_i;
            if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_TRIG_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (cnt_o == '0 && run_o)); // R8
endmodule

// File: rtl/pretrig_slot_table.sv
// Module: shadowed slot table and due-slot arbiter.
// On a trigger it captures delays and channels, and loads the pending set
// from the enables. Each evaluation cycle it selects the lowest-index pending
// slot whose delay has been reached and removes it from the pending set.
// Assumes: eval_i is low in trigger cycles.
module pretrig_slot_table #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned CH_W  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig_i,
    input  logic                   eval_i,
    input  logic [SLOTS-1:0]       en_i,
    input  logic [SLOTS*CNT_W-1:0] dly_i,
    input  logic [SLOTS*CH_W-1:0]  chan_i,
    input  logic [CNT_W-1:0]       cnt_i,
    output logic                   pick_vld_o,
    output logic [CH_W-1:0]        pick_chan_o,
    output logic                   more_o
);
    localparam logic [SLOTS-1:0] ONE = {{(SLOTS-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] dly_sh  [SLOTS];
    logic [CH_W-1:0]  chan_sh [SLOTS];
    logic [SLOTS-1:0] pend_q;
    logic [SLOTS-1:0] due;
    logic [SLOTS-1:0] pick;

    // Capture the programmed table into the shadow copy at each trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                dly_sh[i]  <= '0;
                chan_sh[i] <= '0;
            end
        end else if (trig_i) begin
            for (int i = 0; i < SLOTS; i++) begin
                dly_sh[i]  <= dly_i[i*CNT_W +: CNT_W];
                chan_sh[i] <= chan_i[i*CH_W +: CH_W];
            end
        end
    end

    // Compare each pending slot against the tick counter.
    for (genvar g = 0; g < SLOTS; g++) begin : g_due
        assign due[g] = pend_q[g] & (cnt_i >= dly_sh[g]);
    end

    // Select the lowest-index due slot (isolate its lowest set bit).
    assign pick = eval_i ? (due & (~due + ONE)) : '0;

    // Channel mux for the one-hot selection.
    always_comb begin
        pick_chan_o = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (pick[i]) pick_chan_o = pick_chan_o | chan_sh[i];
        end
    end

    assign pick_vld_o = |pick;
    assign more_o     = |(pend_q & ~pick);

    // Arm the enabled slots on trigger, retire each slot once it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= '0;
        else if (trig_i) pend_q <= en_i;
        else             pend_q <= pend_q & ~pick;
    end

    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick)); // R3
    AST_RETIRED_STAYS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && pick_vld_o) |=> $countones(pend_q) < $countones($past(pend_q))); // R6
endmodule

// File: rtl/pretrig_lock_ctl.sv
// Module: conversion lock and output stage.
// A selected slot starts a conversion when the lock is free or is released by
// conv_done_i in the same cycle. Otherwise it is reported as a sequence error.
// A start sets the lock, and only conv_done_i clears it. Outputs are registered.
module pretrig_lock_ctl #(
    parameter int unsigned CH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pick_vld_i,
    input  logic [CH_W-1:0] pick_chan_i,
    input  logic            conv_done_i,
    output logic            conv_start_o,
    output logic [CH_W-1:0] conv_chan_o,
    output logic            seq_err_o
);
    logic lock_q;
    logic fire;
    logic clash;

    assign fire  = pick_vld_i & (~lock_q | conv_done_i);
    assign clash = pick_vld_i & lock_q & ~conv_done_i;

    // Register start, channel and error; maintain the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start_o <= 1'b0;
            conv_chan_o  <= '0;
            seq_err_o    <= 1'b0;
            lock_q       <= 1'b0;
        end else begin
            conv_start_o <= fire;
            seq_err_o    <= clash;
            if (fire) conv_chan_o <= pick_chan_i;
            lock_q <= fire | (lock_q & ~conv_done_i);
        end
    end

    AST_LOCK_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !conv_done_i) |=> !conv_start_o); // R5
    AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_o |-> $past(lock_q && !conv_done_i)); // R6
    AST_START_SETS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> lock_q); // R5
endmodule

// File: rtl/pretrig_seq.sv
// Module: top of the pre-trigger delay sequencer.
// It ties the tick counter, the shadowed slot table and the lock controller
// together. Slots are evaluated only while running and never in a trigger
// cycle, so a trigger always wins over a due slot.
module pretrig_seq
    import pretrig_seq_pkg::*;
#(
    parameter int unsigned SLOTS = SEQ_SLOTS,
    parameter int unsigned CNT_W = SEQ_CNT_W,
    parameter int unsigned CH_W  = SEQ_CH_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig_i,
    input  logic [SLOTS-1:0]       slot_en_i,
    input  logic [SLOTS*CNT_W-1:0] slot_dly_i,
    input  logic [SLOTS*CH_W-1:0]  slot_chan_i,
    input  logic                   conv_done_i,
    output logic                   conv_start_o,
    output logic [CH_W-1:0]        conv_chan_o,
    output logic                   seq_err_o
);
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic             more;
    logic             eval;
    logic             pick_vld;
    logic [CH_W-1:0]  pick_chan;

    assign eval = run & ~trig_i;

    pretrig_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .more_i (more),
        .cnt_o  (cnt),
        .run_o  (run)
    );

    pretrig_slot_table #(.SLOTS(SLOTS), .CNT_W(CNT_W), .CH_W(CH_W)) u_tab (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_i),
        .eval_i      (eval),
        .en_i        (slot_en_i),
        .dly_i       (slot_dly_i),
        .chan_i      (slot_chan_i),
        .cnt_i       (cnt),
        .pick_vld_o  (pick_vld),
        .pick_chan_o (pick_chan),
        .more_o      (more)
    );

    pretrig_lock_ctl #(.CH_W(CH_W)) u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .pick_vld_i   (pick_vld),
        .pick_chan_i  (pick_chan),
        .conv_done_i  (conv_done_i),
        .conv_start_o (conv_start_o),
        .conv_chan_o  (conv_chan_o),
        .seq_err_o    (seq_err_o)
    );

    AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> $past(run)); // R2
    AST_START_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start_o && seq_err_o)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !trig_i) |=> (!conv_start_o && !seq_err_o)); // R1
endmodule

// File: tb/pretrig_seq_tb_top.sv
`timescale 1ns/1ps
module pretrig_seq_tb_top;
    localparam int SLOTS = 8;
    localparam int CNT_W = 16;
    localparam int CH_W  = 5;
    localparam int TWIN  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic done = 1'b0;
    logic [SLOTS-1:0]       en_v = '0;
    logic [SLOTS*CNT_W-1:0] dly_v = '0;
    logic [SLOTS*CH_W-1:0]  chan_v = '0;
    logic                   start;
    logic [CH_W-1:0]        chan;
    logic                   err;

    int b_dly [SLOTS];
    logic [CH_W-1:0] b_chan [SLOTS];
    logic [SLOTS-1:0] b_en;
    int exp_s [TWIN];
    int exp_e [TWIN];
    int exp_c [TWIN];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pretrig_seq dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .slot_en_i(en_v),
        .slot_dly_i(dly_v), .slot_chan_i(chan_v), .conv_done_i(done),
        .conv_start_o(start), .conv_chan_o(chan), .seq_err_o(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic pack();
        en_v = b_en;
        for (int i = 0; i < SLOTS; i++) begin
            dly_v[i*CNT_W +: CNT_W] = b_dly[i][CNT_W-1:0];
            chan_v[i*CH_W +: CH_W]  = b_chan[i];
        end
    endtask

    task automatic randomize_table();
        b_en = SLOTS'($urandom);
        for (int i = 0; i < SLOTS; i++) begin
            b_dly[i]  = $urandom_range(40, 0);
            b_chan[i] = CH_W'($urandom);
        end
    endtask

    // Expected schedule: per tick t, lowest due slot; start if lock free, else error.
    task automatic expect_sched(input int lat);
        logic [SLOTS-1:0] pend = b_en;
        int lock_until = -1;
        for (int t = 0; t < TWIN; t++) begin
            int sel = -1;
            exp_s[t] = 0; exp_e[t] = 0; exp_c[t] = 0;
            for (int i = SLOTS - 1; i >= 0; i--)
                if (pend[i] && b_dly[i] <= t) sel = i;
            if (sel >= 0) begin
                pend[sel] = 1'b0;
                if (t < lock_until) exp_e[t] = 1;
                else begin
                    exp_s[t] = 1;
                    exp_c[t] = int'(b_chan[sel]);
                    lock_until = t + lat;
                end
            end
        end
    endtask

    // One period: trigger, then compare each cycle and answer starts after lat ticks.
    task automatic run_trial(input int lat, input int ncyc, input bit scramble,
                             input string tag);
        int done_at = -1;
        expect_sched(lat);
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0; done = 1'b0;
        for (int k = 1; k <= ncyc; k++) begin
            string rq;
            @(negedge clk);
            rq = (exp_e[k-1] != 0) ? "R6" : ((exp_s[k-1] != 0) ? "R2" : "R4");
            chk(int'(start) == exp_s[k-1], {rq, "/", tag}, "conv_start", int'(start), exp_s[k-1]);
            chk(int'(err) == exp_e[k-1], {rq, "/", tag}, "seq_err", int'(err), exp_e[k-1]);
            if (exp_s[k-1] != 0)
                chk(int'(chan) == exp_c[k-1], {"R2/", tag}, "conv_chan", int'(chan), exp_c[k-1]);
            if (start) done_at = k + lat - 1;
            done = (k == done_at);
            if (scramble && k == 2) begin
                randomize_table();
                pack();
            end
        end
        @(negedge clk); done = 1'b0;
    endtask

    initial begin
        int first_k;
        int nstart;
        void'($urandom(32'd20240));
        for (int i = 0; i < SLOTS; i++) begin b_dly[i] = 0; b_chan[i] = '0; end
        b_en = '0;
        pack();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset even with completion pulses
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!start && !err && chan == '0, "R1", "idle outputs", int'({start, err, chan}), 0);
            done = k[0];
        end
        done = 1'b0;

        // R2: current at 0, voltage at mid-period, fast converter
        b_en = 8'b0000_0011; b_dly[0] = 0; b_dly[1] = 25; b_chan[0] = 5'd8; b_chan[1] = 5'd2;
        pack(); run_trial(3, TWIN, 1'b0, "R2");

        // R3/R5: tie at delay 5, completion in the same cycle releases the lock
        b_en = 8'b0100_0100; b_dly[2] = 5; b_dly[6] = 5; b_chan[2] = 5'd17; b_chan[6] = 5'd30;
        pack(); run_trial(1, TWIN, 1'b0, "R3_R5");

        // R6: second slot due while locked is dropped with an error
        b_en = 8'b0000_1001; b_dly[0] = 0; b_dly[3] = 1; b_chan[0] = 5'd1; b_chan[3] = 5'd4;
        pack(); run_trial(4, TWIN, 1'b0, "R6");

        // R4: nothing enabled, all delays zero
        b_en = '0;
        for (int i = 0; i < SLOTS; i++) b_dly[i] = 0;
        pack(); run_trial(2, 16, 1'b0, "R4");

        // R8: retrigger mid-sequence discards the pending slot
        b_en = 8'b0000_0011; b_dly[0] = 2; b_dly[1] = 20; b_chan[0] = 5'd3; b_chan[1] = 5'd9;
        pack(); run_trial(2, 10, 1'b0, "R8");
        run_trial(2, TWIN, 1'b0, "R8");

        // R7: random tables rewritten after the trigger; R2/R3/R4/R6 also exercised
        for (int n = 0; n < 30; n++) begin
            randomize_table(); pack();
            run_trial(int'($urandom_range(6, 1)), TWIN, n[0], "R7");
        end

        // R9: maximum delay fires at the 65536th edge
        b_en = 8'b0000_0001; b_dly[0] = 65535; b_chan[0] = 5'd21;
        pack();
        first_k = -1; nstart = 0;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        for (int k = 1; k <= 65540; k++) begin
            @(negedge clk);
            if (start) begin nstart++; if (first_k < 0) first_k = k; end
            done = start;
        end
        done = 1'b0;
        chk(first_k == 65536 && nstart == 1, "R9", "max delay start edge", first_k, 65536);
        chk(int'(chan) == 21, "R9", "max delay channel", int'(chan), 21);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule